// File: doc/BRIEF.md
# Ring Comparison Fault Classifier

This block turns the pass/mismatch bits of a closed ring of pairwise comparators into a verdict for each element of that ring. Each element is a buffer under test. Each comparator watches two neighbouring buffers. Comparator `i` covers buffer `i` and buffer `i+1`, and the last comparator wraps back to buffer 0. A comparator reads 0 when its two buffers agreed and 1 when they differed.

After a start pulse, the engine captures the comparator vector. It then works its way around the ring, one position per clock. First it seeds buffers that are certainly good. Next it spreads good and bad marks through the ring until nothing changes. Finally it sweeps the ring once more to find comparator readings that no assignment of buffer faults can explain. The verdicts and two summary flags stay on the outputs until the next start.

Top module: `cc_ring_diag`

## Requirements
- R1: After reset, every 2-bit verdict field is 00 and `busy`, `done`, `inconsistent` and `diag_unique` are all 0.
- R2: A `start` sampled while idle, or in the cycle where `done` is high, captures `ora_vec`, clears all verdicts and flags, and raises `busy` on the next cycle. A `start` sampled while `busy` is high has no effect. Changes on `ora_vec` after capture have no effect on the result.
- R3: Verdict field `i` sits at `status[2i+1:2i]`. The code 01 means good. A buffer whose two adjacent comparators (`ora_vec[i-1]` and `ora_vec[i]`, indices taken modulo N) both read 0 ends with code 01.
- R4: Spreading marks works on each comparator pair in both directions. A good buffer next to an unmarked buffer marks it good across a 0 reading and bad (code 10) across a 1 reading. A bad buffer marks an unmarked neighbour bad across a 0 reading, since equal faults compare equal. A bad buffer across a 1 reading gives no mark. A mark, once set, never changes during a run.
- R5: The spreading sweep visits pairs in ascending order `i = 0..N-1`, one per clock. Each mark is visible to later pairs in the same sweep. Sweeps repeat until one sweep adds no mark, or until N sweeps have run.
- R6: A buffer that no rule reaches keeps code 00 at the end of the run. Code 11 never appears.
- R7: `inconsistent` is 1 at `done` exactly when some comparator reads 1 between two good buffers, or reads 0 between a good buffer and a bad buffer.
- R8: `diag_unique` is 1 at `done` exactly when no verdict field is 00.
- R9: `done` is high for exactly one cycle, and `busy` is low in that cycle. Verdicts and flags hold their values from `done` until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a classification run |
| ora_vec | input | N | Comparator readings; bit i compares buffer i with buffer i+1 mod N |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| status | output | 2*N | Per-buffer verdict: 00 unknown, 01 good, 10 bad |
| inconsistent | output | 1 | Readings contradict the final marks |
| diag_unique | output | 1 | Every buffer received a verdict |

## Verification
Two things can land in the same cycle: the end-of-run pulse and the acceptance of a new start. The bench raises `start` with a fresh vector exactly in the cycle where `done` is high. It then requires `busy` on the next cycle, and it checks that the second run's verdicts match a model computed only from the new vector. Every 8-bit comparator pattern is swept twice. The first time the inputs are left clean. The second time `ora_vec` is inverted and a stray `start` is pulsed mid-run, and both runs must give identical results.

// File: rtl/cc_diag_pkg.sv
package cc_diag_pkg;

    typedef enum logic [1:0] {
        BUT_UNK = 2'b00,
        BUT_OK  = 2'b01,
        BUT_BAD = 2'b10
    } but_st_e;

    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_SEED  = 3'd1,
        PH_PROP  = 3'd2,
        PH_CHECK = 3'd3,
        PH_DONE  = 3'd4
    } phase_e;

    function automatic logic is_known(input but_st_e s);
        return s != BUT_UNK;
    endfunction

endpackage

// File: rtl/cc_ring_select.sv
module cc_ring_select
    import cc_diag_pkg::*;
#(
    parameter int N  = 8,
    parameter int PW = 3
) (
    input  logic [N-1:0][1:0] stat_i,
    input  logic [N-1:0]      ora_i,
    input  logic [PW-1:0]     pos_i,
    output but_st_e           cur_o,
    output but_st_e           nxt_o,
    output logic              ora_prev_o,
    output logic              ora_cur_o,
    output logic [PW-1:0]     nxt_pos_o
);

    localparam logic [PW-1:0] LAST = PW'(N - 1);

    logic [PW-1:0] prv_pos;

    always_comb begin
        nxt_pos_o  = (pos_i == LAST) ? '0 : pos_i + 1'b1;
        prv_pos    = (pos_i == '0) ? LAST : pos_i - 1'b1;
        cur_o      = but_st_e'(stat_i[pos_i]);
        nxt_o      = but_st_e'(stat_i[nxt_pos_o]);
        ora_cur_o  = ora_i[pos_i];
        ora_prev_o = ora_i[prv_pos];
    end

endmodule

// File: rtl/cc_pair_rule.sv
module cc_pair_rule
    import cc_diag_pkg::*;
(
    input  but_st_e lo_i,
    input  but_st_e hi_i,
    input  logic    ora_i,
    output logic    wr_lo_o,
    output logic    wr_hi_o,
    output but_st_e mark_o,
    output logic    clash_o
);

    but_st_e src;
    logic    lo_free;
    logic    hi_free;
    logic    gives;

    always_comb begin
        lo_free = !is_known(lo_i);
        hi_free = !is_known(hi_i);
        // the known side is the source of information for the unknown side
        src     = lo_free ? hi_i : lo_i;
        mark_o  = BUT_UNK;
        gives   = 1'b0;
        if (src == BUT_OK) begin
            gives  = 1'b1;
            mark_o = ora_i ? BUT_BAD : BUT_OK;
        end else if (src == BUT_BAD && !ora_i) begin
            gives  = 1'b1;
            mark_o = BUT_BAD;
        end
        wr_hi_o = gives && !lo_free && hi_free;
        wr_lo_o = gives && lo_free && !hi_free;

        clash_o = (ora_i && lo_i == BUT_OK && hi_i == BUT_OK) ||
                  (!ora_i && ((lo_i == BUT_OK && hi_i == BUT_BAD) ||
                              (lo_i == BUT_BAD && hi_i == BUT_OK)));
    end

endmodule

// File: rtl/cc_ring_diag.sv
module cc_ring_diag
    import cc_diag_pkg::*;
#(
    parameter int N = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic [N-1:0]   ora_vec,
    output logic           busy,
    output logic           done,
    output logic [2*N-1:0] status,
    output logic           inconsistent,
    output logic           diag_unique
);

    localparam int PW = (N > 1) ? $clog2(N) : 1;
    localparam int CW = $clog2(N + 1);
    localparam logic [PW-1:0] LAST_POS  = PW'(N - 1);
    localparam logic [CW-1:0] LAST_PASS = CW'(N - 1);

    typedef struct packed {
        phase_e             phase;
        logic [PW-1:0]      pos;
        logic [CW-1:0]      pass;
        logic               changed;
        logic [N-1:0]       ora;
        logic [N-1:0][1:0]  stat;
        logic               inc;
        logic               unk;
        logic               uni;
    } diag_state_t;

    diag_state_t q, d;

    but_st_e       cur_st;
    but_st_e       nxt_st;
    logic          ora_prev;
    logic          ora_cur;
    logic [PW-1:0] nxt_pos;
    logic          wr_lo;
    logic          wr_hi;
    but_st_e       mark;
    logic          clash;

    cc_ring_select #(.N(N), .PW(PW)) u_sel (
        .stat_i     (q.stat),
        .ora_i      (q.ora),
        .pos_i      (q.pos),
        .cur_o      (cur_st),
        .nxt_o      (nxt_st),
        .ora_prev_o (ora_prev),
        .ora_cur_o  (ora_cur),
        .nxt_pos_o  (nxt_pos)
    );

    cc_pair_rule u_rule (
        .lo_i    (cur_st),
        .hi_i    (nxt_st),
        .ora_i   (ora_cur),
        .wr_lo_o (wr_lo),
        .wr_hi_o (wr_hi),
        .mark_o  (mark),
        .clash_o (clash)
    );

    always_comb begin
        logic last;
        logic chg;
        d    = q;
        last = (q.pos == LAST_POS);
        chg  = wr_lo | wr_hi;
        unique case (q.phase)
            PH_IDLE, PH_DONE: begin
                if (start) begin
                    d.phase   = PH_SEED;
                    d.pos     = '0;
                    d.pass    = '0;
                    d.changed = 1'b0;
                    d.ora     = ora_vec;
                    d.stat    = '0;
                    d.inc     = 1'b0;
                    d.unk     = 1'b0;
                    d.uni     = 1'b0;
                end else begin
                    d.phase = PH_IDLE;
                end
            end
            PH_SEED: begin
                if (!ora_prev && !ora_cur) begin
                    d.stat[q.pos] = BUT_OK;
                end
                d.pos = nxt_pos;
                if (last) begin
                    d.phase = PH_PROP;
                end
            end
            PH_PROP: begin
                if (wr_lo) begin
                    d.stat[q.pos] = mark;
                end
                if (wr_hi) begin
                    d.stat[nxt_pos] = mark;
                end
                d.pos = nxt_pos;
                if (last) begin
                    d.changed = 1'b0;
                    if (!(q.changed | chg) || q.pass == LAST_PASS) begin
                        d.phase = PH_CHECK;
                    end else begin
                        d.pass = q.pass + 1'b1;
                    end
                end else begin
                    d.changed = q.changed | chg;
                end
            end
            PH_CHECK: begin
                d.inc = q.inc | clash;
                d.unk = q.unk | !is_known(cur_st);
                d.pos = nxt_pos;
                if (last) begin
                    d.uni   = !(q.unk | !is_known(cur_st));
                    d.phase = PH_DONE;
                end
            end
            default: d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{phase: PH_IDLE, default: '0};
        end else begin
            q <= d;
        end
    end

    for (genvar g = 0; g < N; g++) begin : g_out
        assign status[2*g+1:2*g] = q.stat[g];
    end

    assign busy         = (q.phase == PH_SEED) || (q.phase == PH_PROP) ||
                          (q.phase == PH_CHECK);
    assign done         = (q.phase == PH_DONE);
    assign inconsistent = q.inc;
    assign diag_unique  = q.uni;

endmodule

// File: rtl/cc_ring_diag_chk.sv
module cc_ring_diag_chk #(
    parameter int N = 8
) (
    input logic           clk,
    input logic           rst_n,
    input logic           start,
    input logic           busy,
    input logic           done,
    input logic [2*N-1:0] status,
    input logic           inconsistent,
    input logic           diag_unique
);

    logic [N-1:0] unk_bits;
    logic         any_unk;

    for (genvar g = 0; g < N; g++) begin : g_fld
        assign unk_bits[g] = (status[2*g+1:2*g] == 2'b00);

        // R6: code 11 is never produced
        a_r6_no_illegal_code: assert property (@(posedge clk) disable iff (!rst_n)
            status[2*g+1:2*g] != 2'b11);

        // R4: a verdict set during a run is never rewritten
        a_r4_mark_sticky: assert property (@(posedge clk) disable iff (!rst_n)
            (busy && status[2*g+1:2*g] != 2'b00) |=> $stable(status[2*g+1:2*g]));
    end

    assign any_unk = |unk_bits;

    a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r9_busy_done_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));

    a_r2_start_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    a_r9_results_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> ($stable(status) && $stable(inconsistent) &&
                               $stable(diag_unique)));

    a_r8_unique_all_known: assert property (@(posedge clk) disable iff (!rst_n)
        (done && diag_unique) |-> !any_unk);

    a_r8_unknown_not_unique: assert property (@(posedge clk) disable iff (!rst_n)
        (done && any_unk) |-> !diag_unique);

endmodule

bind cc_ring_diag cc_ring_diag_chk #(.N(N)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (start),
    .busy         (busy),
    .done         (done),
    .status       (status),
    .inconsistent (inconsistent),
    .diag_unique  (diag_unique)
);

// File: tb/cc_ring_diag_test.sv
`timescale 1ns/1ps
module cc_ring_diag_test;

    localparam int N = 8;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           start = 1'b0;
    logic [N-1:0]   ora_vec = '0;
    logic           busy;
    logic           done;
    logic [2*N-1:0] status;
    logic           inconsistent;
    logic           diag_unique;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    cc_ring_diag #(.N(N)) uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (start),
        .ora_vec      (ora_vec),
        .busy         (busy),
        .done         (done),
        .status       (status),
        .inconsistent (inconsistent),
        .diag_unique  (diag_unique)
    );

    logic [2*N-1:0] exp_stat;
    logic           exp_inc;
    logic           exp_uni;

    task automatic chk(input logic ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Expected result from the rules: 0 unknown, 1 good, 2 bad
    task automatic model(input logic [N-1:0] o);
        int st[N];
        int a, b, j, k;
        bit ch;
        for (int i = 0; i < N; i++) begin
            st[i] = (!o[(i + N - 1) % N] && !o[i]) ? 1 : 0;
        end
        for (int p = 0; p < N; p++) begin
            ch = 0;
            for (int i = 0; i < N; i++) begin
                j = (i + 1) % N;
                a = st[i];
                b = st[j];
                k = -1;
                if (a != 0 && b == 0) begin
                    if (a == 1) begin st[j] = o[i] ? 2 : 1; ch = 1; end
                    else if (!o[i]) begin st[j] = 2; ch = 1; end
                end else if (b != 0 && a == 0) begin
                    if (b == 1) begin st[i] = o[i] ? 2 : 1; ch = 1; end
                    else if (!o[i]) begin st[i] = 2; ch = 1; end
                end
                if (k > 0) ch = 1;
            end
            if (!ch) break;
        end
        exp_inc = 1'b0;
        exp_uni = 1'b1;
        for (int i = 0; i < N; i++) begin
            a = st[i];
            b = st[(i + 1) % N];
            if (o[i] && a == 1 && b == 1) exp_inc = 1'b1;
            if (!o[i] && ((a == 1 && b == 2) || (a == 2 && b == 1))) exp_inc = 1'b1;
            if (a == 0) exp_uni = 1'b0;
            exp_stat[2*i +: 2] = 2'(a);
        end
    endtask

    task automatic wait_done();
        int w = 0;
        while (!done && w < 2000) begin
            @(negedge clk);
            w++;
        end
        if (!done) chk(1'b0, "R9", "watchdog on done", 0, 1);
    endtask

    task automatic judge(input logic [N-1:0] pat);
        model(pat);
        chk(status == exp_stat, "R3/R4/R5/R6", "verdicts", 32'(status), 32'(exp_stat));
        chk(inconsistent == exp_inc, "R7", "inconsistent flag", 32'(inconsistent), 32'(exp_inc));
        chk(diag_unique == exp_uni, "R8", "unique flag", 32'(diag_unique), 32'(exp_uni));
        chk(busy == 1'b0, "R9", "busy low at done", 32'(busy), 0);
    endtask

    // mode 1 flips ora_vec and pulses start mid-run (R2: both ignored)
    task automatic run_case(input logic [N-1:0] pat, input bit mode);
        @(negedge clk);
        ora_vec = pat;
        start   = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R2", "busy after start", 32'(busy), 1);
        if (mode) begin
            ora_vec = ~pat;
            @(negedge clk);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        wait_done();
        judge(pat);
        @(negedge clk);
        chk(done == 1'b0, "R9", "done one cycle", 32'(done), 0);
        chk(status == exp_stat, "R9", "verdicts held", 32'(status), 32'(exp_stat));
    endtask

    initial begin
        #(4 * 150000);
        chk(1'b0, "R9", "global watchdog", 0, 1);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(status == '0, "R1", "status after reset", 32'(status), 0);
        chk(busy == 1'b0 && done == 1'b0, "R1", "busy/done after reset", {busy, done}, 0);
        chk(inconsistent == 1'b0 && diag_unique == 1'b0, "R1", "flags after reset",
            {inconsistent, diag_unique}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R3 all-good ring; R6 all-mismatch ring stays unknown
        run_case(8'h00, 1'b0);
        chk(diag_unique == 1'b1, "R8", "all-zero ring unique", 32'(diag_unique), 1);
        run_case(8'hFF, 1'b0);
        chk(status == '0, "R6", "all-ones ring unknown", 32'(status), 0);
        // R7 single mismatch cannot be explained
        run_case(8'h01, 1'b0);
        chk(inconsistent == 1'b1, "R7", "lone mismatch", 32'(inconsistent), 1);

        // R4 R5 exhaustive sweeps, clean and perturbed (R2)
        for (int p = 0; p < 256; p++) run_case(8'(p), 1'b0);
        for (int p = 0; p < 256; p++) run_case(8'(p), 1'b1);

        // R2 restart in the done cycle
        @(negedge clk);
        ora_vec = 8'h0C;
        start   = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done();
        judge(8'h0C);
        ora_vec = 8'h30;
        start   = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R2", "restart at done accepted", 32'(busy), 1);
        wait_done();
        judge(8'h30);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule